// File: doc/BRIEF.md
# Bulk Transfer Word/Byte Buffer

This block is the data buffer that sits beside a two-wire bus transaction engine for long composite transfers, from 9 up to 1024 bytes. Software programs the transfer size (as a count minus one) in its own register, separately from the transaction command. It then rewinds the word pointer and moves the payload as 64-bit words through a single access port: it writes words before an outgoing transfer, and it reads them back after an incoming one. The engine consumes or produces the same payload one byte at a time, in message order.

Bytes are packed big-endian: message byte 0 is the most significant byte of word 0. A short final word holds its bytes in the upper lanes, and the lower lanes are zero padding. A two-state controller gates all traffic. In `ST_OFF` every access is ignored. Transition ENTER (`mode_set` with no error) moves to `ST_ON`. Transition LEAVE (`mode_clr` or `err_in`, and the error wins over a set) moves back to `ST_OFF`.

Top module: `bulk_fifo`

## Requirements
- R1: The size register takes the byte count minus one. Each byte side raises its done output (`tx_done` for engine reads, `rx_done` for engine writes) once exactly count bytes have been moved, and not before.
- R2: A `ptr_rst` pulse returns the word pointer to word 0, so the next software read returns word 0.
- R3: Each accepted software write or read moves one full 64-bit word and advances the word pointer by one.
- R4: Byte order is big-endian: message byte k sits in bits [63-8*(k%8) -: 8] of word k/8, and byte 0 is bits 63:56 of word 0.
- R5: When the engine writes a final partial word, the lanes below its last byte read back as zero, whatever that word held before.
- R6: A software read at or beyond the filled depth returns zero and leaves the word pointer where it is.
- R7: `mode_set` enters block mode (`mode_on`=1). `mode_clr` leaves it. `err_in` leaves it, with priority over `mode_set` in the same cycle.
- R8: While block mode is off, software writes and engine writes change nothing, engine reads do not advance, `eng_rd_byte` is zero, and software reads return zero.
- R9: Engine accesses after done are ignored. The done output stays high and `eng_rd_byte` reads zero.
- R10: Writing the size register clears the filled depth and both byte counters.
- R11: After reset the mode is off, `sw_rdata` is zero and both done outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_set | input | 1 | Enter block mode |
| mode_clr | input | 1 | Leave block mode |
| err_in | input | 1 | Transfer error; forces block mode off |
| mode_on | output | 1 | Block mode active |
| cfg_len_we | input | 1 | Write the size register |
| cfg_len_wdata | input | 10 | Byte count minus one |
| ptr_rst | input | 1 | Rewind the word pointer to 0 |
| sw_wr | input | 1 | Software word write strobe |
| sw_wdata | input | 64 | Software write word |
| sw_rd | input | 1 | Software word read strobe |
| sw_rdata | output | 64 | Word returned by the last read |
| eng_wr | input | 1 | Engine byte write strobe |
| eng_wr_byte | input | 8 | Engine byte to store |
| eng_rd | input | 1 | Engine byte read strobe (advance) |
| eng_rd_byte | output | 8 | Current byte for the engine |
| rx_done | output | 1 | All engine-written bytes received |
| tx_done | output | 1 | All engine-read bytes consumed |

## Verification
The bench targets these corner cases:
- **Byte order.** A reversed byte order would show up as the wrong first byte reaching the engine.
- **Stale padding.** An incoming transfer of 11 bytes is written over a word that still holds old data. Missing padding clearing would leak those old bytes into the lower lanes.
- **Reads past the fill.** Reads beyond the filled depth are followed by a write and a rewind. A pointer that moved on an empty read would misplace that word.
- **Error versus set, and mode off.** An error in the same cycle as a set must leave the mode off. Traffic sent while the mode is off must leave the stored words unchanged.
- **Done boundary.** A count that is off by one would raise done a byte early or late.

// File: rtl/bulk_fifo_pkg.sv
package bulk_fifo_pkg;
    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } blk_state_e;
endpackage

// File: rtl/bulk_fifo_mem.sv
module bulk_fifo_mem #(
    parameter int DEPTH      = 128,
    parameter int WORD_BYTES = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int LB = $clog2(WORD_BYTES),
    localparam int BW = AW + LB,
    localparam int W  = WORD_BYTES * 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_word,
    input  logic          b_wr_en,
    input  logic [BW-1:0] b_wr_idx,
    input  logic [7:0]    b_wr_byte,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_word,
    input  logic [BW-1:0] b_rd_idx,
    output logic [7:0]    b_rd_byte
);
    logic [W-1:0] store [DEPTH];
    logic [LB-1:0] wr_lane, rd_lane;
    logic [W-1:0] b_rd_word;

    assign wr_lane = b_wr_idx[LB-1:0];
    assign rd_lane = b_rd_idx[LB-1:0];

    // byte lane 0 is the most significant byte; lane 0 write clears padding
    always_ff @(posedge clk) begin
        if (b_wr_en) begin
            if (wr_lane == '0)
                store[b_wr_idx[BW-1:LB]] <= {b_wr_byte, {(W-8){1'b0}}};
            else
                store[b_wr_idx[BW-1:LB]][(WORD_BYTES-1-int'(wr_lane))*8 +: 8] <= b_wr_byte;
        end
        if (wr_en)
            store[wr_addr] <= wr_word;
    end

    assign rd_word   = store[rd_addr];
    assign b_rd_word = store[b_rd_idx[BW-1:LB]];
    assign b_rd_byte = b_rd_word[(WORD_BYTES-1-int'(rd_lane))*8 +: 8];
endmodule

// File: rtl/bulk_fifo_ctrl.sv
module bulk_fifo_ctrl
    import bulk_fifo_pkg::*;
#(
    parameter int MAX_BYTES  = 1024,
    parameter int WORD_BYTES = 8,
    localparam int DEPTH = MAX_BYTES / WORD_BYTES,
    localparam int AW    = $clog2(DEPTH),
    localparam int LB    = $clog2(WORD_BYTES),
    localparam int BW    = $clog2(MAX_BYTES),
    localparam int PW    = AW + 1,
    localparam int CW    = BW + 1,
    localparam int W     = WORD_BYTES * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_set,
    input  logic          mode_clr,
    input  logic          err_in,
    output logic          mode_on,
    input  logic          cfg_len_we,
    input  logic [BW-1:0] cfg_len_wdata,
    input  logic          ptr_rst,
    input  logic          sw_wr,
    input  logic          sw_rd,
    output logic [W-1:0]  sw_rdata,
    input  logic          eng_wr,
    input  logic          eng_rd,
    output logic [7:0]    eng_rd_byte,
    output logic          rx_done,
    output logic          tx_done,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic          mem_b_wr_en,
    output logic [BW-1:0] mem_b_wr_idx,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [W-1:0]  mem_rd_word,
    output logic [BW-1:0] mem_b_rd_idx,
    input  logic [7:0]    mem_b_rd_byte,
    output logic [PW-1:0] word_ptr,
    output logic [PW-1:0] fill_q,
    output logic [CW-1:0] tx_cnt,
    output logic [CW-1:0] rx_cnt
);
    blk_state_e state_q, state_nx;
    logic [BW-1:0] len_q;
    logic [CW-1:0] total;
    logic [PW-1:0] fill_nx, rx_word_p1, ptr_p1;
    logic active, sw_wr_ok, sw_rd_ok, rx_ok, tx_ok, sw_free;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_nx;
    end

    // transitions: ENTER on set, LEAVE on clear or error (error wins)
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_OFF: if (mode_set && !err_in)   state_nx = ST_ON;
            ST_ON:  if (mode_clr || err_in)    state_nx = ST_OFF;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        active = 1'b0;
        unique case (state_q)
            ST_OFF: active = 1'b0;
            ST_ON:  active = 1'b1;
        endcase
    end

    assign mode_on    = active;
    assign total      = CW'(len_q) + CW'(1);
    assign sw_free    = active && !cfg_len_we && !ptr_rst;
    assign sw_wr_ok   = sw_free && sw_wr && (word_ptr < PW'(DEPTH));
    assign sw_rd_ok   = sw_free && sw_rd && (word_ptr < fill_q);
    assign rx_ok      = active && !cfg_len_we && eng_wr && (rx_cnt < total);
    assign tx_ok      = active && !cfg_len_we && eng_rd && (tx_cnt < total);
    assign rx_done    = (rx_cnt == total);
    assign tx_done    = (tx_cnt == total);
    assign ptr_p1     = word_ptr + PW'(1);
    assign rx_word_p1 = PW'(rx_cnt[BW-1:LB]) + PW'(1);

    always_comb begin
        fill_nx = fill_q;
        if (cfg_len_we) begin
            fill_nx = '0;
        end else begin
            if (sw_wr_ok && ptr_p1 > fill_nx)     fill_nx = ptr_p1;
            if (rx_ok && rx_word_p1 > fill_nx)    fill_nx = rx_word_p1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q    <= '0;
            word_ptr <= '0;
            fill_q   <= '0;
            tx_cnt   <= '0;
            rx_cnt   <= '0;
            sw_rdata <= '0;
        end else begin
            fill_q <= fill_nx;
            if (cfg_len_we) begin
                len_q  <= cfg_len_wdata;
                tx_cnt <= '0;
                rx_cnt <= '0;
            end else begin
                if (rx_ok) rx_cnt <= rx_cnt + CW'(1);
                if (tx_ok) tx_cnt <= tx_cnt + CW'(1);
            end
            if (ptr_rst)                   word_ptr <= '0;
            else if (sw_wr_ok || sw_rd_ok) word_ptr <= ptr_p1;
            if (sw_rd)
                sw_rdata <= sw_rd_ok ? mem_rd_word : '0;
        end
    end

    assign mem_wr_en    = sw_wr_ok;
    assign mem_wr_addr  = word_ptr[AW-1:0];
    assign mem_rd_addr  = word_ptr[AW-1:0];
    assign mem_b_wr_en  = rx_ok;
    assign mem_b_wr_idx = rx_cnt[BW-1:0];
    assign mem_b_rd_idx = tx_cnt[BW-1:0];
    assign eng_rd_byte  = (active && tx_cnt < total) ? mem_b_rd_byte : 8'h00;
endmodule

// File: rtl/bulk_fifo.sv
module bulk_fifo #(
    parameter int MAX_BYTES  = 1024,
    parameter int WORD_BYTES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mode_set,
    input  logic                          mode_clr,
    input  logic                          err_in,
    output logic                          mode_on,
    input  logic                          cfg_len_we,
    input  logic [$clog2(MAX_BYTES)-1:0]  cfg_len_wdata,
    input  logic                          ptr_rst,
    input  logic                          sw_wr,
    input  logic [WORD_BYTES*8-1:0]       sw_wdata,
    input  logic                          sw_rd,
    output logic [WORD_BYTES*8-1:0]       sw_rdata,
    input  logic                          eng_wr,
    input  logic [7:0]                    eng_wr_byte,
    input  logic                          eng_rd,
    output logic [7:0]                    eng_rd_byte,
    output logic                          rx_done,
    output logic                          tx_done
);
    localparam int DEPTH = MAX_BYTES / WORD_BYTES;
    localparam int AW    = $clog2(DEPTH);
    localparam int BW    = $clog2(MAX_BYTES);
    localparam int PW    = AW + 1;
    localparam int CW    = BW + 1;
    localparam int W     = WORD_BYTES * 8;

    logic          mem_wr_en, mem_b_wr_en;
    logic [AW-1:0] mem_wr_addr, mem_rd_addr;
    logic [BW-1:0] mem_b_wr_idx, mem_b_rd_idx;
    logic [W-1:0]  mem_rd_word;
    logic [7:0]    mem_b_rd_byte;
    logic [PW-1:0] word_ptr, fill_q;
    logic [CW-1:0] tx_cnt, rx_cnt;

    bulk_fifo_ctrl #(.MAX_BYTES(MAX_BYTES), .WORD_BYTES(WORD_BYTES)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .mode_set(mode_set), .mode_clr(mode_clr), .err_in(err_in), .mode_on(mode_on),
        .cfg_len_we(cfg_len_we), .cfg_len_wdata(cfg_len_wdata), .ptr_rst(ptr_rst),
        .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_rdata(sw_rdata),
        .eng_wr(eng_wr), .eng_rd(eng_rd), .eng_rd_byte(eng_rd_byte),
        .rx_done(rx_done), .tx_done(tx_done),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_b_wr_en(mem_b_wr_en), .mem_b_wr_idx(mem_b_wr_idx),
        .mem_rd_addr(mem_rd_addr), .mem_rd_word(mem_rd_word),
        .mem_b_rd_idx(mem_b_rd_idx), .mem_b_rd_byte(mem_b_rd_byte),
        .word_ptr(word_ptr), .fill_q(fill_q), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
    );

    bulk_fifo_mem #(.DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES)) i_mem (
        .clk(clk),
        .wr_en(mem_wr_en), .wr_addr(mem_wr_addr), .wr_word(sw_wdata),
        .b_wr_en(mem_b_wr_en), .b_wr_idx(mem_b_wr_idx), .b_wr_byte(eng_wr_byte),
        .rd_addr(mem_rd_addr), .rd_word(mem_rd_word),
        .b_rd_idx(mem_b_rd_idx), .b_rd_byte(mem_b_rd_byte)
    );
endmodule

// File: rtl/bulk_fifo_chk.sv
module bulk_fifo_chk #(
    parameter int PW = 8,
    parameter int CW = 11,
    parameter int W  = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          err_in,
    input logic          mode_on,
    input logic          cfg_len_we,
    input logic          ptr_rst,
    input logic          sw_wr,
    input logic          sw_rd,
    input logic [W-1:0]  sw_rdata,
    input logic          tx_done,
    input logic [PW-1:0] word_ptr,
    input logic [PW-1:0] fill_q,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt
);
    AST_ERR_CLEARS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        err_in |=> !mode_on); // R7

    AST_PTR_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rst |=> (word_ptr == '0)); // R2

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rd && !sw_wr && !ptr_rst && word_ptr >= fill_q) |=> (sw_rdata == '0) && $stable(word_ptr)); // R6

    AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rd && mode_on && !sw_wr && !ptr_rst && !cfg_len_we && word_ptr < fill_q)
        |=> (word_ptr == $past(word_ptr) + PW'(1))); // R3

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !cfg_len_we) |=> (tx_done && $stable(tx_cnt))); // R9

    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_on && !cfg_len_we) |=> ($stable(tx_cnt) && $stable(rx_cnt))); // R8
endmodule

bind bulk_fifo bulk_fifo_chk #(.PW(PW), .CW(CW), .W(W)) i_chk (
    .clk(clk), .rst_n(rst_n), .err_in(err_in), .mode_on(mode_on),
    .cfg_len_we(cfg_len_we), .ptr_rst(ptr_rst), .sw_wr(sw_wr), .sw_rd(sw_rd),
    .sw_rdata(sw_rdata), .tx_done(tx_done), .word_ptr(word_ptr), .fill_q(fill_q),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/test_bulk_fifo.sv
`timescale 1ns/1ps
module test_bulk_fifo;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_set = 0, mode_clr = 0, err_in = 0, mode_on;
    logic cfg_len_we = 0;
    logic [9:0] cfg_len_wdata = '0;
    logic ptr_rst = 0, sw_wr = 0, sw_rd = 0;
    logic [63:0] sw_wdata = '0, sw_rdata;
    logic eng_wr = 0, eng_rd = 0;
    logic [7:0] eng_wr_byte = '0, eng_rd_byte;
    logic rx_done, tx_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [63:0] exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    bulk_fifo i_bulk_fifo (
        .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .mode_clr(mode_clr),
        .err_in(err_in), .mode_on(mode_on), .cfg_len_we(cfg_len_we),
        .cfg_len_wdata(cfg_len_wdata), .ptr_rst(ptr_rst), .sw_wr(sw_wr),
        .sw_wdata(sw_wdata), .sw_rd(sw_rd), .sw_rdata(sw_rdata), .eng_wr(eng_wr),
        .eng_wr_byte(eng_wr_byte), .eng_rd(eng_rd), .eng_rd_byte(eng_rd_byte),
        .rx_done(rx_done), .tx_done(tx_done)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_cycle();
        @(negedge clk);
    endtask

    task automatic write_len(input int count);
        cfg_len_wdata = 10'(count - 1); cfg_len_we = 1; pulse_cycle(); cfg_len_we = 0;
    endtask

    task automatic rewind();
        ptr_rst = 1; pulse_cycle(); ptr_rst = 0;
    endtask

    task automatic sw_write(input logic [63:0] w);
        sw_wdata = w; sw_wr = 1; pulse_cycle(); sw_wr = 0;
    endtask

    // driver: push the expected word, then issue the read
    task automatic sw_read_exp(input logic [63:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        sw_rd = 1; pulse_cycle(); sw_rd = 0;
    endtask

    // monitor: compare each read result after the capturing edge
    initial begin
        forever begin
            @(posedge clk);
            if (sw_rd) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard: actual=%h expected=<none>", sw_rdata);
                end else begin
                    check(sw_rdata, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(mode_on, 0, "R11 mode after reset");
        check(sw_rdata, 0, "R11 rdata after reset");
        check({rx_done, tx_done}, 0, "R11 done after reset");
        rst_n = 1;
        pulse_cycle();

        // R7 enter mode
        mode_set = 1; pulse_cycle(); mode_set = 0;
        check(mode_on, 1, "R7 set enters mode");

        // outgoing transfer of 10 bytes
        write_len(10);                       // R1 R10
        rewind();                            // R2
        sw_write(64'h0102030405060708);      // R3
        sw_write(64'h1112131415161718);
        for (int k = 0; k < 10; k++) begin
            logic [7:0] e;
            e = (k < 8) ? 8'(k + 1) : 8'(8'h11 + (k - 8));
            check(eng_rd_byte, e, $sformatf("R4 tx byte %0d", k));
            check(tx_done, 0, "R1 tx done early");
            eng_rd = 1; pulse_cycle(); eng_rd = 0;
        end
        check(tx_done, 1, "R1 tx done after count");
        eng_rd = 1; pulse_cycle(); eng_rd = 0;
        check(tx_done, 1, "R9 done holds");
        check(eng_rd_byte, 0, "R9 byte after done");

        // read back, beyond-fill reads, pointer held
        rewind();
        sw_read_exp(64'h0102030405060708, "R2 word0 after rewind");
        sw_read_exp(64'h1112131415161718, "R3 word1");
        sw_read_exp(64'h0, "R6 beyond fill");
        sw_read_exp(64'h0, "R6 beyond fill again");
        sw_write(64'hCAFE0000BEEF5555);
        rewind();
        sw_read_exp(64'h0102030405060708, "R6 word0");
        sw_read_exp(64'h1112131415161718, "R6 word1");
        sw_read_exp(64'hCAFE0000BEEF5555, "R6 pointer unchanged by empty read");

        // incoming transfer of 11 bytes over stale word1
        write_len(11);
        rewind();
        sw_read_exp(64'h0, "R10 fill cleared by size write");
        for (int k = 0; k < 11; k++) begin
            check(rx_done, 0, "R1 rx done early");
            eng_wr_byte = 8'(8'hA0 + k); eng_wr = 1; pulse_cycle(); eng_wr = 0;
        end
        check(rx_done, 1, "R1 rx done after count");
        eng_wr_byte = 8'h77; eng_wr = 1; pulse_cycle(); eng_wr = 0;
        check(rx_done, 1, "R9 rx done holds");
        rewind();
        sw_read_exp(64'hA0A1A2A3A4A5A6A7, "R4 rx word0");
        sw_read_exp(64'hA8A9AA0000000000, "R5 partial word padding");
        sw_read_exp(64'h0, "R6 rx beyond fill");

        // R7 error wins over set; R8 mode off ignores traffic
        err_in = 1; pulse_cycle(); err_in = 0;
        check(mode_on, 0, "R7 error clears mode");
        mode_set = 1; err_in = 1; pulse_cycle(); mode_set = 0; err_in = 0;
        check(mode_on, 0, "R7 error beats set");
        rewind();
        sw_write(64'hFFFFFFFFFFFFFFFF);
        sw_read_exp(64'h0, "R8 read while off");
        check(eng_rd_byte, 0, "R8 engine byte while off");
        eng_wr_byte = 8'h55; eng_wr = 1; pulse_cycle(); eng_wr = 0;
        mode_set = 1; pulse_cycle(); mode_set = 0;
        check(mode_on, 1, "R7 set after error");
        rewind();
        sw_read_exp(64'hA0A1A2A3A4A5A6A7, "R8 word0 untouched");
        sw_read_exp(64'hA8A9AA0000000000, "R8 word1 untouched");
        mode_clr = 1; pulse_cycle(); mode_clr = 0;
        check(mode_on, 0, "R7 clear leaves mode");

        pulse_cycle();
        pulse_cycle();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule